// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets processors in a multi-core cluster signal each other through a small register window. Every processor owns an 8-byte slot holding a control word and a status word. When a processor writes its control word with the generate bit set, the block places a message in the destination processor's status word and raises that processor's interrupt line. The message carries the sender's index and a 16-bit payload.

The receiving processor reads its status word to learn who called and why. It then clears its interrupt by writing its own control word with the acknowledge bit set. Each destination holds one message only, so a newer message replaces an older one that is still pending. Register reads are combinational from the address. Writes take effect at the next rising clock edge. The active-low reset is applied asynchronously and its release is synchronised to the clock inside the block.

Top module: `ipi_mailbox`

## Requirements
- R1: The slot index is the byte address shifted right by 3. Address bit 2 selects the register: 0 is control, 1 is status. Address bits 1:0 are ignored. A slot index at or above NUM_CPU reads as zero, and writes to it change nothing.
- R2: A write to a control register stores the whole 32-bit word, and a later read of that control register returns the same word.
- R3: A control write with bit 30 (generate) set and a destination field in bits 29:16 below NUM_CPU sets up the destination's status word as follows:
  - bit 31 is 0;
  - bit 30 (pending) is 1;
  - bits 29:16 hold the writer's slot index;
  - bits 15:0 hold the payload from bits 15:0 of the write.
  The destination's interrupt output is high from the next clock cycle.
- R4: A control write with bit 31 (acknowledge) set clears bit 30 of the writer's own status word and keeps its other bits. The writer's interrupt output is low from the next cycle.
- R5: When one write sets both the generate and the acknowledge bits, generation is applied first and acknowledgement second. A processor that targets itself in such a write ends with the new sender and payload in its status word and with pending clear.
- R6: Writes to a status register change no register and no interrupt output.
- R7: A generate request whose destination field is at or above NUM_CPU changes no status word and raises no interrupt.
- R8: A generate request to a destination that is already pending replaces the stored sender and payload with the new ones, and the pending flag stays set.
- R9: During reset and after it, every control and status word reads zero and every interrupt output is low. Each interrupt output equals bit 30 of its processor's status word and changes only after a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ipi_irq | output | NUM_CPU | Level interrupt, one bit per processor |

## Verification
A wrong pending flag shows on `ipi_irq` in the cycle after the control write that caused it, because the interrupt line is taken straight from the stored flag. A wrong sender, payload or control word stays hidden until software reads that slot. For that reason the bench reads back every status word and the writer's control word after every write.

The sweep covers every pair of writer and destination, including destinations outside the configured range, with each combination of the generate and acknowledge bits. Any decode slip or any error in the order of generate and acknowledge therefore shows up as a status or interrupt mismatch within one write.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  localparam int WORD_W   = 32;
  localparam int ID_W     = 14;
  localparam int MSG_W    = 16;
  localparam int ACK_BIT  = 31;
  localparam int GEN_BIT  = 30;
  localparam int PEND_BIT = 30;
  localparam int ID_LSB   = 16;

  function automatic logic [WORD_W-1:0] pack_status(input logic [ID_W-1:0] src,
                                                    input logic [MSG_W-1:0] msg);
    return {2'b01, src, msg};
  endfunction
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 6,
  localparam int IDX_W  = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [IDX_W-1:0]  slot_idx,
  output logic              slot_ok,
  output logic              sel_status,
  output logic [NUM_CPU-1:0] ctrl_we_vec,
  output logic [NUM_CPU-1:0] gen_vec,
  output logic [NUM_CPU-1:0] ack_vec,
  output logic [ID_W-1:0]   src_id
);
  logic [ID_W-1:0] dst_id;
  logic            ctrl_wr;
  logic [1:0]      unused_byte_off;

  assign unused_byte_off = addr[1:0];
  assign slot_idx   = addr[ADDR_W-1:3];
  assign sel_status = addr[2];
  assign slot_ok    = int'(slot_idx) < NUM_CPU;
  assign ctrl_wr    = we && !sel_status && slot_ok;
  assign dst_id     = wdata[ID_LSB +: ID_W];
  assign src_id     = ID_W'(slot_idx);

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_dec
    assign ctrl_we_vec[i] = ctrl_wr && (slot_idx == IDX_W'(i));
    assign ack_vec[i]     = ctrl_we_vec[i] && wdata[ACK_BIT];
    assign gen_vec[i]     = ctrl_wr && wdata[GEN_BIT] && (dst_id == ID_W'(i));
  end
endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot
  import ipi_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              gen_hit,
  input  logic [ID_W-1:0]   gen_src,
  input  logic              ack_hit,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] status_q,
  output logic              irq
);
  logic [WORD_W-1:0] status_nxt;
  logic              status_en;

  always_comb begin
    status_nxt = status_q;
    if (gen_hit) status_nxt = pack_status(gen_src, wdata[MSG_W-1:0]);
    if (ack_hit) status_nxt[PEND_BIT] = 1'b0;
  end

  assign status_en = gen_hit || ack_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= '0;
    end else begin
      if (ctrl_we)   ctrl_q   <= wdata;
      if (status_en) status_q <= status_nxt;
    end
  end

  assign irq = status_q[PEND_BIT];
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CPU-1:0] ipi_irq
);
  localparam int IDX_W = ADDR_W - 3;

  logic                           rst_sync_n;
  logic [IDX_W-1:0]               slot_idx;
  logic                           slot_ok;
  logic                           sel_status;
  logic [NUM_CPU-1:0]             ctrl_we_vec;
  logic [NUM_CPU-1:0]             gen_vec;
  logic [NUM_CPU-1:0]             ack_vec;
  logic [ID_W-1:0]                src_id;
  logic [NUM_CPU-1:0][WORD_W-1:0] ctrl_arr;
  logic [NUM_CPU-1:0][WORD_W-1:0] stat_arr;

  ipi_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ipi_addr_dec #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
    .addr        (bus_addr),
    .we          (bus_we),
    .wdata       (bus_wdata),
    .slot_idx    (slot_idx),
    .slot_ok     (slot_ok),
    .sel_status  (sel_status),
    .ctrl_we_vec (ctrl_we_vec),
    .gen_vec     (gen_vec),
    .ack_vec     (ack_vec),
    .src_id      (src_id)
  );

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_slot
    ipi_cpu_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .ctrl_we  (ctrl_we_vec[i]),
      .wdata    (bus_wdata),
      .gen_hit  (gen_vec[i]),
      .gen_src  (src_id),
      .ack_hit  (ack_vec[i]),
      .ctrl_q   (ctrl_arr[i]),
      .status_q (stat_arr[i]),
      .irq      (ipi_irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (slot_ok) begin
      for (int i = 0; i < NUM_CPU; i++) begin
        if (slot_idx == IDX_W'(i)) bus_rdata = sel_status ? stat_arr[i] : ctrl_arr[i];
      end
    end
  end
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NUM_CPU-1:0] ipi_irq
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] slot;
  logic [13:0]      dst;
  logic             slot_ok, is_ctrl, dst_ok;
  logic [1:0]       unused_low;

  assign unused_low = bus_addr[1:0];
  assign slot    = bus_addr[ADDR_W-1:3];
  assign is_ctrl = !bus_addr[2];
  assign slot_ok = int'(slot) < NUM_CPU;
  assign dst     = bus_wdata[29:16];
  assign dst_ok  = int'(dst) < NUM_CPU;

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_ok |-> bus_rdata == 32'd0); // R1

  AST_OOR_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !slot_ok |=> $stable(ipi_irq)); // R1

  AST_STATUS_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !is_ctrl |=> $stable(ipi_irq)); // R6

  AST_BAD_DST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && is_ctrl && !bus_wdata[31] && !(bus_wdata[30] && dst_ok) |=> $stable(ipi_irq)); // R7

  AST_IDLE_IRQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(ipi_irq)); // R9

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    AST_GEN_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && is_ctrl && slot_ok && bus_wdata[30] && dst == 14'(i)
      && !(bus_wdata[31] && slot == IDX_W'(i)) |=> ipi_irq[i]); // R3

    AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && is_ctrl && bus_wdata[31] && slot == IDX_W'(i) |=> !ipi_irq[i]); // R4
  end
endmodule

bind ipi_mailbox ipi_mailbox_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ipi_irq   (ipi_irq)
);

// File: tb/ipi_mailbox_bench.sv
`timescale 1ns/1ps
module ipi_mailbox_bench;
  localparam int N  = 4;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  ipi_irq;

  int checks = 0;
  int fails  = 0;

  logic [31:0] ctrl_m [N];
  logic [31:0] stat_m [N];

  always #2.5 clk = ~clk;

  ipi_mailbox #(.NUM_CPU(N), .ADDR_W(AW)) u_ipi_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ipi_irq(ipi_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    bus_we   = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    int slot = a >> 3;
    @(negedge clk);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    if (slot < N && ((a >> 2) & 1) == 0) begin
      ctrl_m[slot] = d;
      if (d[30] && int'(d[29:16]) < N)
        stat_m[d[29:16]] = {2'b01, 14'(slot), d[15:0]};
      if (d[31]) stat_m[slot][30] = 1'b0;
    end
  endtask

  function automatic logic [31:0] irq_exp();
    logic [31:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = stat_m[i][30];
    return v;
  endfunction

  task automatic check_all(input string req);
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin
      rd(i * 8 + 4, d);
      chk(req, d, stat_m[i]);
      rd(i * 8, d);
      chk("R2", d, ctrl_m[i]);
    end
    chk("R9", 32'(ipi_irq), irq_exp());
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; rst_n = 1'b0;
    for (int i = 0; i < N; i++) begin ctrl_m[i] = '0; stat_m[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R9", 32'(ipi_irq), 32'd0);
    rd(4, d); chk("R9", d, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R9");

    // sweep: writer x destination (incl. out of range) x gen/ack combinations
    for (int s = 0; s < N; s++)
      for (int t = 0; t < N + 2; t++)
        for (int m = 0; m < 4; m++) begin
          logic [31:0] w;
          string req;
          w = {m[1], m[0], 14'(t), 16'((s * 4099 + t * 257 + m * 31) & 16'hffff)};
          if (m == 3 && t < N) req = "R5";
          else if (m[0] && t >= N) req = "R7";
          else if (m[0]) req = "R3";
          else if (m[1]) req = "R4";
          else req = "R2";
          wr(s * 8 + (m & 3 & {1'b0, t[0]}), w);
          check_all(req);
        end

    // self target with both bits
    wr(2 * 8, {2'b11, 14'd2, 16'hbeef});
    check_all("R5");
    rd(2 * 8 + 4, d); chk("R5", d, {2'b00, 14'd2, 16'hbeef});

    // overwrite of a pending message
    wr(0, {2'b01, 14'd3, 16'h1111});
    wr(1 * 8, {2'b01, 14'd3, 16'h2222});
    rd(3 * 8 + 4, d); chk("R8", d, {2'b01, 14'd1, 16'h2222});
    chk("R8", 32'(ipi_irq[3]), 32'd1);

    // status writes ignored
    for (int i = 0; i < N; i++) begin
      wr(i * 8 + 4, 32'hffff_ffff);
      check_all("R6");
    end

    // out-of-range slots
    for (int s = N; s < (1 << (AW - 3)); s++) begin
      wr(s * 8, {2'b11, 14'd0, 16'h5a5a});
      check_all("R1");
      rd(s * 8, d); chk("R1", d, 32'd0);
      rd(s * 8 + 4, d); chk("R1", d, 32'd0);
    end

    // byte offset bits ignored on read
    rd(3 * 8 + 7, d); chk("R1", d, stat_m[3]);
    rd(1 * 8 + 3, d); chk("R1", d, ctrl_m[1]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule